// File: doc/BRIEF.md
# PCI Bridge Parity Error Responder

This block is the parity checking and error reaction logic of a two-port PCI-to-PCI bridge. It checks the address phase on the primary and secondary buses, and the data phase of Type 0 configuration writes aimed at the bridge itself. For each of these phases it forms the even parity of the AD and C/BE# lines and compares it with the PAR sample taken one clock later.

When it finds a mismatch, it can do three things. It can tell the claim logic of the affected bus not to assert DEVSEL#. It can pulse the primary PERR# or SERR# pin. It keeps the sticky status bits that software reads and clears by writing one. Each bus has its own gate for its response: the command register gates the primary side and the bridge control register gates the secondary side. SERR# also needs the SERR# enable bit.

The surrounding bridge supplies the phase strobes and the register enable bits. It uses the claim-inhibit pulses in its DEVSEL# decode and drives the active-low pins from the outputs. A data parity error on a configuration write never stops the write: TRDY# and the commit of the data stay with the caller and are not affected.

Top module: `pci_parity_guard`

## Requirements
- R1: Parity is even over AD[31:0], C/BE[3:0] and PAR, with PAR sampled in the clock after the phase. When the parity is correct, there is no pulse on any output and every status bit stays 0.
- R2: A primary address parity error with cmd_reg bit 6 set makes pri_claim_blk high for exactly one clock, two clocks after the address phase. With bit 6 clear, pri_claim_blk stays low.
- R3: Every primary address parity error sets pri_stat bit 15, whatever the enable bits are.
- R4: A primary address parity error drives pri_serr_n low for exactly one clock, two clocks after the address phase, and sets pri_stat bit 14. Both happen only when cmd_reg bit 8 and bit 6 are both set.
- R5: A secondary address parity error with bctl_reg bit 0 set makes sec_claim_blk high for exactly one clock, two clocks after the phase. pri_claim_blk stays low. With bit 0 clear, sec_claim_blk stays low.
- R6: Every secondary address parity error sets sec_stat bit 15, whatever the enable bits are.
- R7: A secondary address parity error pulses pri_serr_n low for one clock, two clocks after the phase, and sets pri_stat bit 14. Both happen only when cmd_reg bit 8 and bctl_reg bit 0 are both set.
- R8: A data parity error in a flagged configuration-write data phase drives pri_perr_n low for one clock, two clocks after the phase, only when cmd_reg bit 6 is set. It always sets pri_stat bit 15 and never raises a claim inhibit.
- R9: Status bits are sticky. A one in pri_clr or sec_clr at a bit position clears that bit. A set and a clear in the same clock leave the bit set. All other status bits read 0.
- R10: After reset, pri_perr_n and pri_serr_n are high, both claim-inhibit outputs are low and both status words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_ad | input | 32 | Primary AD lines |
| pri_cbe | input | 4 | Primary C/BE# lines |
| pri_par | input | 1 | Primary PAR, valid one clock after the phase |
| pri_addr_vld | input | 1 | Primary address phase in this clock |
| pri_cfgwr_vld | input | 1 | Data phase of a Type 0 configuration write to the bridge in this clock |
| sec_ad | input | 32 | Secondary AD lines |
| sec_cbe | input | 4 | Secondary C/BE# lines |
| sec_par | input | 1 | Secondary PAR, valid one clock after the phase |
| sec_addr_vld | input | 1 | Secondary address phase in this clock |
| cmd_reg | input | 16 | Command register (bit 6 parity response, bit 8 SERR# enable) |
| bctl_reg | input | 16 | Bridge control register (bit 0 secondary parity response) |
| pri_clr | input | 16 | Write-one-to-clear mask for pri_stat |
| sec_clr | input | 16 | Write-one-to-clear mask for sec_stat |
| pri_claim_blk | output | 1 | One-clock pulse: do not assert primary DEVSEL# |
| sec_claim_blk | output | 1 | One-clock pulse: do not assert secondary DEVSEL# |
| pri_perr_n | output | 1 | Primary PERR#, active low |
| pri_serr_n | output | 1 | Primary SERR#, active low |
| pri_stat | output | 16 | Primary status (bit 15 detected parity, bit 14 signaled system error) |
| sec_stat | output | 16 | Secondary status (bit 15 detected parity) |

## Verification
Suppose a checker loses its pending flag or its stored parity. The error then shows up at the ports two clocks after the phase in the wrong form: a missing or extra claim-inhibit pulse, a missing or extra PERR# or SERR# pulse, or no change to the status word in that same clock. A gate decode that looks at the wrong enable bit becomes visible as soon as the bench varies that bit alone. A status bit that fails to hold, or that clears when a set arrives, shows as a wrong status word one clock after the clear or set is applied.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int PPG_NCH  = 3;
    localparam int CH_PADDR = 0;
    localparam int CH_SADDR = 1;
    localparam int CH_CFGD  = 2;

    typedef struct packed {
        logic pend;
        logic sum;
    } ppg_chk_t;

    typedef struct packed {
        logic pri_blk;
        logic sec_blk;
        logic serr;
        logic perr;
    } ppg_resp_t;
endpackage

// File: rtl/ppg_par_chk.sv
module ppg_par_chk
    import ppg_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_vld,
    input  logic [W-1:0] bits,
    input  logic         par,
    output logic         err
);
    ppg_chk_t st_d, st_q;

    always_comb begin
        st_d.pend = phase_vld;
        st_d.sum  = ^bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // even parity: stored sum plus PAR must be zero
    assign err = st_q.pend & (st_q.sum ^ par);
endmodule

// File: rtl/ppg_stat_bit.sv
module ppg_stat_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic bit_d, bit_q;

    always_comb bit_d = (bit_q & ~clr) | set;

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign q = bit_q;
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
    import ppg_pkg::*;
#(
    parameter int AD_W       = 32,
    parameter int CBE_W      = 4,
    parameter int REG_W      = 16,
    parameter int CMD_PER    = 6,
    parameter int CMD_SERREN = 8,
    parameter int BCTL_PER   = 0,
    parameter int STAT_DPE   = 15,
    parameter int STAT_SSE   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  pri_ad,
    input  logic [CBE_W-1:0] pri_cbe,
    input  logic             pri_par,
    input  logic             pri_addr_vld,
    input  logic             pri_cfgwr_vld,
    input  logic [AD_W-1:0]  sec_ad,
    input  logic [CBE_W-1:0] sec_cbe,
    input  logic             sec_par,
    input  logic             sec_addr_vld,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic [REG_W-1:0] bctl_reg,
    input  logic [REG_W-1:0] pri_clr,
    input  logic [REG_W-1:0] sec_clr,
    output logic             pri_claim_blk,
    output logic             sec_claim_blk,
    output logic             pri_perr_n,
    output logic             pri_serr_n,
    output logic [REG_W-1:0] pri_stat,
    output logic [REG_W-1:0] sec_stat
);
    localparam int PW = AD_W + CBE_W;

    logic [PPG_NCH-1:0][PW-1:0] ch_bits;
    logic [PPG_NCH-1:0]         ch_vld;
    logic [PPG_NCH-1:0]         ch_par;
    logic [PPG_NCH-1:0]         ch_err;

    always_comb begin
        ch_bits[CH_PADDR] = {pri_cbe, pri_ad};
        ch_vld[CH_PADDR]  = pri_addr_vld;
        ch_par[CH_PADDR]  = pri_par;
        ch_bits[CH_SADDR] = {sec_cbe, sec_ad};
        ch_vld[CH_SADDR]  = sec_addr_vld;
        ch_par[CH_SADDR]  = sec_par;
        ch_bits[CH_CFGD]  = {pri_cbe, pri_ad};
        ch_vld[CH_CFGD]   = pri_cfgwr_vld;
        ch_par[CH_CFGD]   = pri_par;
    end

    for (genvar c = 0; c < PPG_NCH; c++) begin : g_chk
        ppg_par_chk #(.W(PW)) i_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase_vld(ch_vld[c]),
            .bits     (ch_bits[c]),
            .par      (ch_par[c]),
            .err      (ch_err[c])
        );
    end

    logic pri_per, sec_per, serr_en;
    assign pri_per = cmd_reg[CMD_PER];
    assign sec_per = bctl_reg[BCTL_PER];
    assign serr_en = cmd_reg[CMD_SERREN];

    ppg_resp_t rs_d, rs_q;

    always_comb begin
        rs_d.pri_blk = ch_err[CH_PADDR] & pri_per;
        rs_d.sec_blk = ch_err[CH_SADDR] & sec_per;
        rs_d.serr    = serr_en & ((ch_err[CH_PADDR] & pri_per) |
                                  (ch_err[CH_SADDR] & sec_per));
        rs_d.perr    = ch_err[CH_CFGD] & pri_per;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    logic pri_dpe, pri_sse, sec_dpe;

    ppg_stat_bit i_pri_dpe (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ch_err[CH_PADDR] | ch_err[CH_CFGD]),
        .clr  (pri_clr[STAT_DPE]),
        .q    (pri_dpe)
    );

    ppg_stat_bit i_pri_sse (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (rs_d.serr),
        .clr  (pri_clr[STAT_SSE]),
        .q    (pri_sse)
    );

    ppg_stat_bit i_sec_dpe (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ch_err[CH_SADDR]),
        .clr  (sec_clr[STAT_DPE]),
        .q    (sec_dpe)
    );

    always_comb begin
        pri_stat           = '0;
        pri_stat[STAT_DPE] = pri_dpe;
        pri_stat[STAT_SSE] = pri_sse;
        sec_stat           = '0;
        sec_stat[STAT_DPE] = sec_dpe;
    end

    assign pri_claim_blk = rs_q.pri_blk;
    assign sec_claim_blk = rs_q.sec_blk;
    assign pri_perr_n    = ~rs_q.perr;
    assign pri_serr_n    = ~rs_q.serr;
endmodule

// File: rtl/ppg_sva.sv
module ppg_sva #(
    parameter int REG_W      = 16,
    parameter int CMD_PER    = 6,
    parameter int CMD_SERREN = 8,
    parameter int BCTL_PER   = 0,
    parameter int STAT_DPE   = 15,
    parameter int STAT_SSE   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] cmd_reg,
    input logic [REG_W-1:0] bctl_reg,
    input logic [REG_W-1:0] pri_clr,
    input logic             pri_claim_blk,
    input logic             sec_claim_blk,
    input logic             pri_perr_n,
    input logic             pri_serr_n,
    input logic [REG_W-1:0] pri_stat,
    input logic [REG_W-1:0] sec_stat
);
    p_pri_blk_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pri_claim_blk |-> ($past(cmd_reg[CMD_PER]) && pri_stat[STAT_DPE]));

    p_serr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_serr_n |-> ($past(cmd_reg[CMD_SERREN]) && pri_stat[STAT_SSE]));

    p_sec_blk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_claim_blk |-> ($past(bctl_reg[BCTL_PER]) && sec_stat[STAT_DPE]));

    p_perr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_perr_n |-> ($past(cmd_reg[CMD_PER]) && pri_stat[STAT_DPE] && !pri_claim_blk));

    p_sticky_dpe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pri_stat[STAT_DPE]) && !$past(pri_clr[STAT_DPE])) |-> pri_stat[STAT_DPE]);

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pri_stat) <= 2) && ($countones(sec_stat) <= 1));
endmodule

bind pci_parity_guard ppg_sva #(
    .REG_W     (REG_W),
    .CMD_PER   (CMD_PER),
    .CMD_SERREN(CMD_SERREN),
    .BCTL_PER  (BCTL_PER),
    .STAT_DPE  (STAT_DPE),
    .STAT_SSE  (STAT_SSE)
) i_ppg_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_reg      (cmd_reg),
    .bctl_reg     (bctl_reg),
    .pri_clr      (pri_clr),
    .pri_claim_blk(pri_claim_blk),
    .sec_claim_blk(sec_claim_blk),
    .pri_perr_n   (pri_perr_n),
    .pri_serr_n   (pri_serr_n),
    .pri_stat     (pri_stat),
    .sec_stat     (sec_stat)
);

// File: tb/test_pci_parity_guard.sv
module test_pci_parity_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pri_ad = '0, sec_ad = '0;
    logic [3:0]  pri_cbe = '0, sec_cbe = '0;
    logic        pri_par = 1'b0, sec_par = 1'b0;
    logic        pri_addr_vld = 1'b0, pri_cfgwr_vld = 1'b0, sec_addr_vld = 1'b0;
    logic [15:0] cmd_reg = '0, bctl_reg = '0, pri_clr = '0, sec_clr = '0;
    logic        pri_claim_blk, sec_claim_blk, pri_perr_n, pri_serr_n;
    logic [15:0] pri_stat, sec_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pci_parity_guard i_pci_parity_guard (
        .clk(clk), .rst_n(rst_n),
        .pri_ad(pri_ad), .pri_cbe(pri_cbe), .pri_par(pri_par),
        .pri_addr_vld(pri_addr_vld), .pri_cfgwr_vld(pri_cfgwr_vld),
        .sec_ad(sec_ad), .sec_cbe(sec_cbe), .sec_par(sec_par),
        .sec_addr_vld(sec_addr_vld),
        .cmd_reg(cmd_reg), .bctl_reg(bctl_reg),
        .pri_clr(pri_clr), .sec_clr(sec_clr),
        .pri_claim_blk(pri_claim_blk), .sec_claim_blk(sec_claim_blk),
        .pri_perr_n(pri_perr_n), .pri_serr_n(pri_serr_n),
        .pri_stat(pri_stat), .sec_stat(sec_stat)
    );

    // packed view of all outputs: {pblk, sblk, perr_n, serr_n, pri_stat, sec_stat}
    function automatic logic [35:0] outs();
        return {pri_claim_blk, sec_claim_blk, pri_perr_n, pri_serr_n, pri_stat, sec_stat};
    endfunction

    function automatic logic [35:0] mk(logic pb, logic sb, logic pe_n, logic se_n,
                                       logic [15:0] ps, logic [15:0] ss);
        return {pb, sb, pe_n, se_n, ps, ss};
    endfunction

    task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // kind: 0 primary address, 1 secondary address, 2 config write data
    // Returns outputs two clocks after the phase and one clock later.
    task automatic phase(int kind, logic [31:0] ad, logic [3:0] cbe, logic bad,
                         logic [15:0] pclr, output logic [35:0] at2, output logic [35:0] at3);
        @(negedge clk);
        if (kind == 1) begin sec_ad = ad; sec_cbe = cbe; sec_addr_vld = 1'b1; end
        else begin
            pri_ad = ad; pri_cbe = cbe;
            if (kind == 0) pri_addr_vld = 1'b1; else pri_cfgwr_vld = 1'b1;
        end
        @(negedge clk);
        pri_addr_vld = 1'b0; pri_cfgwr_vld = 1'b0; sec_addr_vld = 1'b0;
        if (kind == 1) sec_par = (^{ad, cbe}) ^ bad;
        else           pri_par = (^{ad, cbe}) ^ bad;
        pri_clr = pclr;
        @(negedge clk);
        at2 = outs();
        pri_par = 1'b0; sec_par = 1'b0; pri_clr = '0;
        @(negedge clk);
        at3 = outs();
    endtask

    task automatic clear_all();
        @(negedge clk);
        pri_clr = 16'hFFFF; sec_clr = 16'hFFFF;
        @(negedge clk);
        pri_clr = '0; sec_clr = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 reset state", outs(), mk(0, 0, 1, 1, 16'h0, 16'h0));
    endtask

    task automatic t_good();
        logic [35:0] a, b;
        cmd_reg = 16'h0140; bctl_reg = 16'h0001;
        phase(0, 32'hDEAD_BEEF, 4'h6, 0, '0, a, b);
        chk("R1 good primary address", a, mk(0, 0, 1, 1, 0, 0));
        phase(1, 32'h1234_5670, 4'hA, 0, '0, a, b);
        chk("R1 good secondary address", a, mk(0, 0, 1, 1, 0, 0));
        phase(2, 32'h0000_0001, 4'hF, 0, '0, a, b);
        chk("R1 good config data", a, mk(0, 0, 1, 1, 0, 0));
    endtask

    task automatic t_pri();
        logic [35:0] a, b;
        cmd_reg = 16'h0140; bctl_reg = 16'h0;
        phase(0, 32'hA5A5_0F0F, 4'h7, 1, '0, a, b);
        chk("R2 R4 primary error, both enables", a, mk(1, 0, 1, 0, 16'hC000, 0));
        chk("R2 R4 single clock pulses", b, mk(0, 0, 1, 1, 16'hC000, 0));
        clear_all();
        cmd_reg = 16'h0100;
        phase(0, 32'h0000_0000, 4'h0, 1, '0, a, b);
        chk("R2 R3 R4 response bit clear", a, mk(0, 0, 1, 1, 16'h8000, 0));
        clear_all();
        cmd_reg = 16'h0040;
        phase(0, 32'hFFFF_FFFF, 4'h3, 1, '0, a, b);
        chk("R4 SERR enable clear", a, mk(1, 0, 1, 1, 16'h8000, 0));
        clear_all();
    endtask

    task automatic t_sec();
        logic [35:0] a, b;
        cmd_reg = 16'h0100; bctl_reg = 16'h0001;
        phase(1, 32'h8000_0001, 4'hC, 1, '0, a, b);
        chk("R5 R6 R7 secondary error, enables set", a, mk(0, 1, 1, 0, 16'h4000, 16'h8000));
        chk("R5 R7 single clock pulses", b, mk(0, 0, 1, 1, 16'h4000, 16'h8000));
        clear_all();
        bctl_reg = 16'h0;
        phase(1, 32'h0F0F_F0F0, 4'h1, 1, '0, a, b);
        chk("R5 R6 R7 bridge response bit clear", a, mk(0, 0, 1, 1, 0, 16'h8000));
        clear_all();
        cmd_reg = 16'h0040; bctl_reg = 16'h0001;
        phase(1, 32'h0000_0003, 4'h2, 1, '0, a, b);
        chk("R7 secondary with SERR enable clear", a, mk(0, 1, 1, 1, 0, 16'h8000));
        clear_all();
    endtask

    task automatic t_cfg();
        logic [35:0] a, b;
        cmd_reg = 16'h0140; bctl_reg = 16'h0001;
        phase(2, 32'hCAFE_0042, 4'h0, 1, '0, a, b);
        chk("R8 config data error, response set", a, mk(0, 0, 0, 1, 16'h8000, 0));
        chk("R8 PERR single clock", b, mk(0, 0, 1, 1, 16'h8000, 0));
        clear_all();
        cmd_reg = 16'h0100;
        phase(2, 32'hCAFE_0042, 4'h0, 1, '0, a, b);
        chk("R8 config data error, response clear", a, mk(0, 0, 1, 1, 16'h8000, 0));
        clear_all();
    endtask

    task automatic t_w1c();
        logic [35:0] a, b;
        cmd_reg = 16'h0140; bctl_reg = 16'h0;
        phase(0, 32'h1111_2222, 4'h5, 1, '0, a, b);
        chk("R9 bits set before clear", b, mk(0, 0, 1, 1, 16'hC000, 0));
        // clear bit15 in the same clock a new error sets it: stays set; bit14 cleared
        cmd_reg = 16'h0000;
        phase(0, 32'h1111_2222, 4'h5, 1, 16'hC000, a, b);
        chk("R9 set wins over clear", b, mk(0, 0, 1, 1, 16'h8000, 0));
        @(negedge clk);
        pri_clr = 16'h3FFF;
        @(negedge clk);
        pri_clr = '0;
        chk("R9 clear of other bits has no effect", outs(), mk(0, 0, 1, 1, 16'h8000, 0));
        @(negedge clk);
        pri_clr = 16'h8000;
        @(negedge clk);
        pri_clr = '0;
        chk("R9 write one clears", outs(), mk(0, 0, 1, 1, 0, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_good();
        t_pri();
        t_sec();
        t_cfg();
        t_w1c();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule